// File: doc/BRIEF.md
# Two-Slot Static Pair Issue Checker

This block is the issue decision point of a two-way superscalar pipeline with slot positions fixed by the compiler. Each clock it can take a 64-bit fetch packet that carries two 32-bit instructions. The upper half feeds the integer slot and the lower half feeds the floating-point slot. The block latches the packet into a two-entry stage. From the stage it decides whether nothing, the integer-slot instruction alone, the FP-slot instruction alone, or both leave for execution in the current cycle.

A one-entry record holds the load issued in the previous issue cycle. This record enforces the one-cycle load-use delay. A load result cannot feed its own packet partner. It also cannot feed either instruction of the next issue cycle. When only the integer-slot instruction can leave, the other one stays in the stage and is issued alone later, and no new packet is taken. A redirect from the branch unit discards whatever remains in the stage.

Top module: `pp_pair_issue`

## Requirements
- R1: While reset is high, and after it is released with no packet taken, both issue outputs and fetch_hold are low.
- R2: Packet encoding. The integer slot is pkt[63:32] and the FP slot is pkt[31:0]. Each instruction carries a class in bits [31:29]: 0 integer ALU, 1 integer load, 2 FP load, 3 branch, 4 FP operation, and 5 to 7 behave as integer ALU. It carries a destination in [24:20] and two sources in [19:15] and [14:10]. A packet whose left instruction is not class 4 and whose right instruction is class 4 issues both slots in the cycle after it is taken, provided no hazard applies.
- R3: The FP-slot instruction never issues in a cycle where the integer-slot instruction is still in the stage and does not issue.
- R4: A packet that cannot pair works as follows. This covers a right instruction of any class other than 4, or a class-4 instruction in the left slot. The left instruction issues alone, and fetch_hold is high in that cycle. In the next cycle the right instruction issues alone.
- R5: Two things are a cross-slot hazard: a load in the left slot, and a right instruction that reads that load's destination in the same register file. When this happens, the left instruction issues and the right one is held back.
- R6: Class-4 instructions read the FP file, and all other classes read the integer file. A load issued in the previous issue cycle blocks any stage instruction that reads its destination in the same file. If the left instruction is blocked, both slots are held. The block lasts exactly one cycle, during which fetch_hold is high.
- R7: An integer load does not block an FP read of the same register number, and an FP load does not block an integer read of the same number.
- R8: A branch (class 3) in the integer slot pairs with a class-4 instruction in the FP slot, and both issue together.
- R9: While redirect is high, nothing issues and fetch_hold is high. The stage is emptied and the offered packet is not taken.
- R10: A valid packet is taken at an edge only when fetch_hold and redirect are both low. A packet offered while fetch_hold is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Fetch packet on pkt is valid |
| pkt | input | 64 | Fetch packet: integer slot upper half, FP slot lower half |
| redirect | input | 1 | Branch-unit redirect; drops the stage contents |
| iss_left | output | 1 | Integer-slot instruction issues this cycle |
| iss_right | output | 1 | FP-slot instruction issues this cycle |
| fetch_hold | output | 1 | Packet offered at the coming edge will not be taken |

## Verification
A packet taken at edge N is visible on iss_left, iss_right and fetch_hold throughout the cycle after N. An instruction held back by pairing appears one cycle later again. A load-use stall adds exactly one cycle, so a cross-slot FP load dependence reaches the right instruction two cycles after the packet. The bench drives inputs and samples outputs at the falling edge, always sampling before it drives. Redirect acts within the cycle it is raised, so the bench checks it 1 ns after driving it. A sweep covers all 64 class pairs, and directed sequences check each stall length cycle by cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_IALU = 3'd0,
    CL_ILD  = 3'd1,
    CL_FLD  = 3'd2,
    CL_BR   = 3'd3,
    CL_FOP  = 3'd4
  } cls_e;
endpackage

// File: rtl/pp_decode.sv
module pp_decode
  import pp_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int REG_W  = 5
) (
  input  logic [INSN_W-1:0] insn,
  output logic              ld,
  output logic              wr_fp,
  output logic              rd_fp,
  output logic              fp_kind,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  sa,
  output logic [REG_W-1:0]  sb
);
  localparam int CLS_HI = INSN_W - 1;
  localparam int DST_HI = INSN_W - 8;
  localparam int SA_HI  = DST_HI - REG_W;
  localparam int SB_HI  = SA_HI - REG_W;
  localparam int SB_LO  = SB_HI - REG_W + 1;

  logic [CLS_W-1:0] cls;
  logic             spare_unused;

  assign cls = insn[CLS_HI -: CLS_W];
  assign dst = insn[DST_HI -: REG_W];
  assign sa  = insn[SA_HI -: REG_W];
  assign sb  = insn[SB_HI -: REG_W];
  assign spare_unused = ^{insn[CLS_HI-CLS_W:DST_HI+1], insn[SB_LO-1:0]};

  always_comb begin
    ld      = (cls == CL_ILD) || (cls == CL_FLD);
    wr_fp   = (cls == CL_FLD);
    fp_kind = (cls == CL_FOP);
    rd_fp   = fp_kind;
  end
endmodule

// File: rtl/pp_hazard.sv
module pp_hazard #(
  parameter int REG_W = 5
) (
  input  logic             prod_v,
  input  logic             prod_fp,
  input  logic [REG_W-1:0] prod_dst,
  input  logic             cons_fp,
  input  logic [REG_W-1:0] cons_a,
  input  logic [REG_W-1:0] cons_b,
  output logic             hit
);
  always_comb begin
    hit = prod_v && (prod_fp == cons_fp) &&
          ((prod_dst == cons_a) || (prod_dst == cons_b));
  end
endmodule

// File: rtl/pp_pair_issue.sv
module pp_pair_issue #(
  parameter int INSN_W = 32,
  parameter int REG_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_valid,
  input  logic [2*INSN_W-1:0]   pkt,
  input  logic                  redirect,
  output logic                  iss_left,
  output logic                  iss_right,
  output logic                  fetch_hold
);
  localparam int NSLOT = 2;
  localparam int SL    = 1;
  localparam int SR    = 0;

  logic [INSN_W-1:0] ins_q [NSLOT];
  logic [NSLOT-1:0]  v_q;

  logic [NSLOT-1:0]  ld_s, wrfp_s, rdfp_s, fpk_s;
  logic [REG_W-1:0]  dst_s [NSLOT];
  logic [REG_W-1:0]  sa_s  [NSLOT];
  logic [REG_W-1:0]  sb_s  [NSLOT];

  logic              pl_v, pl_fp;
  logic [REG_W-1:0]  pl_dst;

  logic hz_l, hz_r, hz_x;
  logic lft_go, rgt_go, pair_ok, drain;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    pp_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) u_dec (
      .insn   (ins_q[g]),
      .ld     (ld_s[g]),
      .wr_fp  (wrfp_s[g]),
      .rd_fp  (rdfp_s[g]),
      .fp_kind(fpk_s[g]),
      .dst    (dst_s[g]),
      .sa     (sa_s[g]),
      .sb     (sb_s[g])
    );
  end

  pp_hazard #(.REG_W(REG_W)) u_hz_left (
    .prod_v(pl_v), .prod_fp(pl_fp), .prod_dst(pl_dst),
    .cons_fp(rdfp_s[SL]), .cons_a(sa_s[SL]), .cons_b(sb_s[SL]), .hit(hz_l)
  );

  pp_hazard #(.REG_W(REG_W)) u_hz_right (
    .prod_v(pl_v), .prod_fp(pl_fp), .prod_dst(pl_dst),
    .cons_fp(rdfp_s[SR]), .cons_a(sa_s[SR]), .cons_b(sb_s[SR]), .hit(hz_r)
  );

  pp_hazard #(.REG_W(REG_W)) u_hz_cross (
    .prod_v(ld_s[SL]), .prod_fp(wrfp_s[SL]), .prod_dst(dst_s[SL]),
    .cons_fp(rdfp_s[SR]), .cons_a(sa_s[SR]), .cons_b(sb_s[SR]), .hit(hz_x)
  );

  always_comb begin
    pair_ok = !fpk_s[SL] && fpk_s[SR];
    lft_go  = v_q[SL] && !redirect && !hz_l;
    rgt_go  = v_q[SR] && !redirect && !hz_r &&
              (v_q[SL] ? (lft_go && pair_ok && !hz_x) : 1'b1);
    drain   = (!v_q[SL] || lft_go) && (!v_q[SR] || rgt_go);
  end

  assign iss_left   = lft_go;
  assign iss_right  = rgt_go;
  assign fetch_hold = redirect || !drain;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= '0;
      pl_v   <= 1'b0;
      pl_fp  <= 1'b0;
      pl_dst <= '0;
    end else begin
      if (lft_go && ld_s[SL]) begin
        pl_v   <= 1'b1;
        pl_fp  <= wrfp_s[SL];
        pl_dst <= dst_s[SL];
      end else if (rgt_go && ld_s[SR]) begin
        pl_v   <= 1'b1;
        pl_fp  <= wrfp_s[SR];
        pl_dst <= dst_s[SR];
      end else begin
        pl_v   <= 1'b0;
      end

      if (redirect) begin
        v_q <= '0;
      end else if (drain) begin
        ins_q[SL] <= pkt[2*INSN_W-1:INSN_W];
        ins_q[SR] <= pkt[INSN_W-1:0];
        v_q       <= {NSLOT{pkt_valid}};
      end else begin
        v_q[SL] <= v_q[SL] && !lft_go;
        v_q[SR] <= v_q[SR] && !rgt_go;
      end
    end
  end

  // R3
  right_needs_left_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_right && v_q[SL]) |-> iss_left);

  // R9
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (!iss_left && !iss_right && fetch_hold));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!fetch_hold && pkt_valid && !redirect) |=> (v_q == 2'b11));

  // R6
  stall_one_chk: assert property (@(posedge clk) disable iff (rst)
    (v_q[SL] && !iss_left && !redirect) |=> !pl_v);

  // R4
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_hold && !redirect) |=> (v_q != 2'b00));
endmodule

// File: tb/test_pp_pair_issue.sv
module test_pp_pair_issue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pkt_valid = 1'b0;
  logic [63:0] pkt = '0;
  logic        redirect = 1'b0;
  logic        iss_left, iss_right, fetch_hold;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pp_pair_issue i_pp_pair_issue (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt(pkt),
    .redirect(redirect), .iss_left(iss_left), .iss_right(iss_right),
    .fetch_hold(fetch_hold)
  );

  function automatic logic [31:0] mk(input int c, input int d, input int a, input int b);
    mk = {c[2:0], 4'b0, d[4:0], a[4:0], b[4:0], 10'b0};
  endfunction

  task automatic expect3(input logic el, input logic er, input logic eh, input string req);
    checks++;
    if (iss_left !== el || iss_right !== er || fetch_hold !== eh) begin
      errors++;
      $display("FAIL %s: got L=%b R=%b H=%b exp L=%b R=%b H=%b",
               req, iss_left, iss_right, fetch_hold, el, er, eh);
    end
  endtask

  task automatic drive(input logic v, input logic [63:0] p, input logic rd);
    pkt_valid = v;
    pkt       = p;
    redirect  = rd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect3(0, 0, 0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    expect3(0, 0, 0, "R1 after reset");

    // Sweep of all class pairs, registers chosen so no hazard applies
    for (int lc = 0; lc < 8; lc++) begin
      for (int rc = 0; rc < 8; rc++) begin
        logic pair;
        pair = (lc != 4) && (rc == 4);
        drive(1, {mk(lc, 1, 2, 3), mk(rc, 4, 10, 11)}, 0);
        @(negedge clk);
        expect3(1, pair, !pair, (lc == 3) ? "R8 branch pair" : "R2/R4 pairing");
        drive(0, '0, 0);
        if (!pair) begin
          @(negedge clk);
          expect3(0, 1, 0, "R4 right alone");
        end
        @(negedge clk);
        expect3(0, 0, 0, "R10 drained");
      end
    end

    // Cross-slot FP load dependence
    drive(1, {mk(2, 7, 1, 2), mk(4, 5, 7, 12)}, 0);
    @(negedge clk);
    expect3(1, 0, 1, "R5 cross hold");
    drive(0, '0, 0);
    @(negedge clk);
    expect3(0, 0, 1, "R6 delay on held right");
    @(negedge clk);
    expect3(0, 1, 0, "R6 right released");
    @(negedge clk);

    // Integer load blocks left of next packet, so both wait
    drive(1, {mk(1, 3, 1, 2), mk(4, 4, 20, 21)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R2 pair with load");
    drive(1, {mk(0, 6, 3, 8), mk(4, 5, 22, 23)}, 0);
    @(negedge clk);
    expect3(0, 0, 1, "R6 whole packet stall");
    drive(1, {mk(0, 6, 1, 2), mk(0, 5, 1, 2)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R6/R10 held packet issues, offer ignored");
    drive(0, '0, 0);
    @(negedge clk);
    expect3(0, 0, 0, "R10 drained");

    // FP load blocks right of next packet only
    drive(1, {mk(2, 9, 1, 2), mk(4, 4, 20, 21)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R2 FP load pair");
    drive(1, {mk(0, 6, 1, 2), mk(4, 5, 9, 23)}, 0);
    @(negedge clk);
    expect3(1, 0, 1, "R6 right blocked");
    drive(0, '0, 0);
    @(negedge clk);
    expect3(0, 1, 0, "R6 one cycle");
    @(negedge clk);

    // Register file separation
    drive(1, {mk(1, 9, 1, 2), mk(4, 4, 20, 21)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R2 pair");
    drive(1, {mk(0, 6, 1, 2), mk(4, 5, 9, 23)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R7 int load vs FP read");
    drive(0, '0, 0);
    @(negedge clk);
    drive(1, {mk(2, 3, 1, 2), mk(4, 4, 20, 21)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R2 pair");
    drive(1, {mk(0, 6, 3, 3), mk(4, 5, 24, 25)}, 0);
    @(negedge clk);
    expect3(1, 1, 0, "R7 FP load vs int read");
    drive(0, '0, 0);
    @(negedge clk);

    // Redirect drops held right and refuses offered packet
    drive(1, {mk(0, 1, 2, 3), mk(0, 4, 5, 6)}, 0);
    @(negedge clk);
    expect3(1, 0, 1, "R4 unpaired");
    drive(1, {mk(0, 1, 2, 3), mk(4, 4, 5, 6)}, 1);
    #1;
    expect3(0, 0, 1, "R9 redirect gates issue");
    @(negedge clk);
    drive(0, '0, 0);
    #1;
    expect3(0, 0, 0, "R9 stage dropped");
    @(negedge clk);
    expect3(0, 0, 0, "R9 nothing taken");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule